// File: doc/BRIEF.md
# Serial Receiver with Node Address Filter

This block is the receive half of an asynchronous serial port. It watches an idle-high serial line, finds start bits, and recovers either eight data bits (short frames) or nine data bits (long frames, used by multidrop buses to tag address bytes), followed by one stop bit. Each bit is judged at its centre by a vote of three samples taken on a 16x oversample tick supplied from outside. The baud tick generator and the transmitter live elsewhere.

When node filtering is enabled, the block raises its receive-done flag only for frames that carry the address qualifier (the ninth bit in long frames, the stop bit in short frames) and whose byte matches this node's address, either directly under a don't-care mask or as a broadcast. All other traffic passes without disturbing the host. A stop bit sampled low raises a sticky framing-error flag that is held apart from the data path and cleared only by its own clear input.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_done_o, ferr_o, rx_byte_o and rx_bit9_o are all 0.
- R2: With nine_bit_i = 0 the frame is a low start bit, 8 data bits least significant first, then a stop bit; with mp_en_i = 0 every such frame loads rx_byte_o, copies the sampled stop bit to rx_bit9_o and sets rx_done_o.
- R3: With nine_bit_i = 1 the frame carries 9 data bits least significant first; bits 0..7 go to rx_byte_o and the ninth bit goes to rx_bit9_o.
- R4: Each bit is decided by a majority vote over three oversample ticks at the bit centre, so a disturbance of one tick period inside a bit does not change the received value.
- R5: A low pulse on the idle line shorter than half a bit time is rejected as a start bit and produces no frame.
- R6: A stop bit sampled low sets ferr_o; it stays set through later frames with good stop bits until ferr_clr_i is high, and a new framing error in the same cycle as ferr_clr_i wins.
- R7: done_clr_i clears rx_done_o; an accepted frame completing in the same cycle as done_clr_i wins and leaves rx_done_o set.
- R8: With mp_en_i = 1 a frame is accepted only if its qualifier bit is 1 (ninth bit when nine_bit_i = 1, stop bit when nine_bit_i = 0) and its byte matches; a rejected frame leaves rx_byte_o, rx_bit9_o and rx_done_o unchanged.
- R9: A byte matches the node address when every bit position with node_mask_i = 0 equals node_addr_i; positions with node_mask_i = 1 are ignored.
- R10: A byte also matches as a broadcast when it has a 1 at every position where node_addr_i OR node_mask_i is 1; zeros of that OR are don't-care.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial line, idle high, asynchronous |
| os_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| nine_bit_i | input | 1 | 1 = nine data bits per frame, 0 = eight |
| mp_en_i | input | 1 | Enables qualifier and address filtering |
| node_addr_i | input | 8 | Node address for comparison |
| node_mask_i | input | 8 | 1 marks address bits ignored in comparison |
| done_clr_i | input | 1 | Clears rx_done_o |
| ferr_clr_i | input | 1 | Clears ferr_o |
| rx_byte_o | output | 8 | Last accepted data byte |
| rx_bit9_o | output | 1 | Ninth bit (long frames) or stop bit (short frames) of last accepted frame |
| rx_done_o | output | 1 | Accepted-frame flag |
| ferr_o | output | 1 | Sticky framing-error flag |

## Verification
Two collisions can occur in one cycle: a frame completing while the host clears rx_done_o, and a bad stop bit while the host clears ferr_o. The bench provokes both by holding the respective clear input high across an entire frame, so the completion edge is bound to coincide with an active clear. It then counts the cycles in which the flag reads high and expects exactly one, which shows the set took priority and the still-asserted clear removed it on the next edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              lvl,
  input  logic              nine_i,
  output logic              done_o,
  output logic [DATA_W:0]   data_o,
  output logic              stop_o,
  output logic              nine_o
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_W + 2);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] C_S0   = CW'(MID - 1);
  localparam logic [CW-1:0] C_S1   = CW'(MID);
  localparam logic [CW-1:0] C_DEC  = CW'(MID + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] B_LONG  = BW'(DATA_W);
  localparam logic [BW-1:0] B_SHORT = BW'(DATA_W - 1);

  rx_state_e        state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [1:0]       smp;
  logic             prev_lvl;
  logic             bit_v;
  logic [BW-1:0]    last_idx;

  assign bit_v    = maj3(smp[1], smp[0], lvl);
  assign last_idx = nine_o ? B_LONG : B_SHORT;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      smp      <= '0;
      prev_lvl <= 1'b1;
      data_o   <= '0;
      stop_o   <= 1'b0;
      nine_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          prev_lvl <= lvl;
          if (prev_lvl && !lvl) begin
            state  <= ST_START;
            cnt    <= '0;
            bidx   <= '0;
            nine_o <= nine_i;
            data_o <= '0;
          end
        end else begin
          cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
          if (cnt == C_S0 || cnt == C_S1)
            smp <= {smp[0], lvl};
          if (cnt == C_DEC) begin
            case (state)
              ST_START: if (bit_v) begin
                state    <= ST_IDLE;
                prev_lvl <= 1'b1;
              end
              ST_DATA: data_o[bidx] <= bit_v;
              ST_STOP: begin
                stop_o   <= bit_v;
                done_o   <= 1'b1;
                state    <= ST_IDLE;
                prev_lvl <= bit_v;
              end
              default: ;
            endcase
          end
          if (cnt == C_LAST) begin
            case (state)
              ST_START: state <= ST_DATA;
              ST_DATA: begin
                bidx <= bidx + BW'(1);
                if (bidx == last_idx) state <= ST_STOP;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] bcast;
  logic              own_hit;
  logic              bcast_hit;

  assign bcast     = addr_i | mask_i;
  assign own_hit   = ((byte_i ^ addr_i) & ~mask_i) == '0;
  assign bcast_hit = (byte_i & bcast) == bcast;
  assign hit_o     = own_hit | bcast_hit;
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              os_tick_i,
  input  logic              nine_bit_i,
  input  logic              mp_en_i,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic [DATA_W-1:0] node_mask_i,
  input  logic              done_clr_i,
  input  logic              ferr_clr_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_bit9_o,
  output logic              rx_done_o,
  output logic              ferr_o
);
  logic            line_lvl;
  logic            frm_done;
  logic [DATA_W:0] frm_data;
  logic            frm_stop;
  logic            frm_nine;
  logic            addr_hit;
  logic            qual;
  logic            accept;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd_i), .dout(line_lvl)
  );

  rx_frame_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst(rst), .tick(os_tick_i), .lvl(line_lvl),
    .nine_i(nine_bit_i), .done_o(frm_done), .data_o(frm_data),
    .stop_o(frm_stop), .nine_o(frm_nine)
  );

  rx_addr_match #(.DATA_W(DATA_W)) u_match (
    .byte_i(frm_data[DATA_W-1:0]), .addr_i(node_addr_i),
    .mask_i(node_mask_i), .hit_o(addr_hit)
  );

  assign qual   = frm_nine ? frm_data[DATA_W] : frm_stop;
  assign accept = frm_done && (!mp_en_i || (qual && addr_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte_o <= '0;
      rx_bit9_o <= 1'b0;
      rx_done_o <= 1'b0;
      ferr_o    <= 1'b0;
    end else begin
      if (accept) begin
        rx_byte_o <= frm_data[DATA_W-1:0];
        rx_bit9_o <= qual;
        rx_done_o <= 1'b1;
      end else if (done_clr_i) begin
        rx_done_o <= 1'b0;
      end
      if (frm_done && !frm_stop) ferr_o <= 1'b1;
      else if (ferr_clr_i)       ferr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_done,
  input logic [DATA_W:0]   frm_data,
  input logic              frm_stop,
  input logic              frm_nine,
  input logic              mp_en,
  input logic              done_clr,
  input logic              ferr_clr,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_done,
  input logic              ferr
);
  logic q_bit;
  assign q_bit = frm_nine ? frm_data[DATA_W] : frm_stop;

  p_byte_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !frm_done |=> $stable(rx_byte));

  p_ferr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ferr && !ferr_clr) |=> ferr);

  p_ferr_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ferr) |-> $past(frm_done && !frm_stop));

  p_done_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (done_clr && !frm_done) |=> !rx_done);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !mp_en) |=> rx_done);

  p_filter_r8: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mp_en && !q_bit && !rx_done) |=> !rx_done);

  p_done_src_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(frm_done));
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .frm_done(frm_done), .frm_data(frm_data),
  .frm_stop(frm_stop), .frm_nine(frm_nine), .mp_en(mp_en_i),
  .done_clr(done_clr_i), .ferr_clr(ferr_clr_i), .rx_byte(rx_byte_o),
  .rx_done(rx_done_o), .ferr(ferr_o)
);

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;
  localparam int BITCLK = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic os_tick = 1'b0;
  logic nine = 1'b0;
  logic mp_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] mask = 8'h00;
  logic done_clr = 1'b0;
  logic ferr_clr = 1'b0;
  logic [7:0] rx_byte;
  logic rx_bit9, rx_done, ferr;

  int n_chk = 0, n_fail = 0, tdiv = 0;
  int done_hi = 0, ferr_hi = 0;
  bit mon_on = 1'b0, finished = 1'b0;

  logic [7:0] e_byte = 8'h00;
  logic       e_b9 = 1'b0, e_done = 1'b0, e_ferr = 1'b0;

  always #10 clk = ~clk;

  uart_addr_rx u_dut (
    .clk(clk), .rst(rst), .rxd_i(rxd), .os_tick_i(os_tick),
    .nine_bit_i(nine), .mp_en_i(mp_en), .node_addr_i(addr),
    .node_mask_i(mask), .done_clr_i(done_clr), .ferr_clr_i(ferr_clr),
    .rx_byte_o(rx_byte), .rx_bit9_o(rx_bit9), .rx_done_o(rx_done),
    .ferr_o(ferr)
  );

  always @(negedge clk) begin
    os_tick <= (tdiv == 3);
    tdiv <= (tdiv + 1) % 4;
    if (mon_on) begin
      if (rx_done) done_hi++;
      if (ferr) ferr_hi++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    chk(req, "rx_byte", rx_byte, e_byte);
    chk(req, "rx_bit9", rx_bit9, e_b9);
    chk(req, "rx_done", rx_done, e_done);
    chk(req, "ferr", ferr, e_ferr);
  endtask

  function automatic bit addr_ok(input logic [7:0] b);
    bit own = 1'b1, bc = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (!mask[i] && (b[i] != addr[i])) own = 1'b0;
      if ((addr[i] || mask[i]) && !b[i]) bc = 1'b0;
    end
    return own || bc;
  endfunction

  task automatic model(input logic [8:0] f, input logic stp);
    logic q;
    q = nine ? f[8] : stp;
    if (!mp_en || (q && addr_ok(f[7:0]))) begin
      e_byte = f[7:0];
      e_b9   = q;
      e_done = 1'b1;
    end
    if (!stp) e_ferr = 1'b1;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] f, input logic stp, input int glitch_bit = -1);
    int nb;
    nb = nine ? 9 : 8;
    hold(1'b0, BITCLK);
    for (int i = 0; i < nb; i++) begin
      if (i == glitch_bit) begin
        hold(f[i], 30); hold(~f[i], 4); hold(f[i], 30);
      end else hold(f[i], BITCLK);
    end
    hold(stp, BITCLK);
    hold(1'b1, 8);
    model(f, stp);
  endtask

  task automatic clr_done();
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0; @(negedge clk);
    e_done = 1'b0;
  endtask

  task automatic clr_ferr();
    ferr_clr = 1'b1; @(negedge clk); ferr_clr = 1'b0; @(negedge clk);
    e_ferr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    cmp_all("R1");

    // R2: short frame, no filtering, good stop
    send(9'h0A5, 1'b1); cmp_all("R2");
    clr_done(); chk("R7", "done after clear", rx_done, 0);

    // R3: long frames
    nine = 1'b1;
    send(9'h13C, 1'b1); cmp_all("R3");
    clr_done();
    send(9'h05A, 1'b1); cmp_all("R3");
    clr_done();

    // R4: one-tick disturbance inside data bit 0 and bit 5
    nine = 1'b0;
    send(9'h00F, 1'b1, 0); cmp_all("R4");
    clr_done();
    send(9'h021, 1'b1, 5); cmp_all("R4");
    clr_done();

    // R5: short low pulse on idle line
    hold(1'b0, 20); hold(1'b1, 400);
    cmp_all("R5");
    send(9'h3C, 1'b1); cmp_all("R5");
    clr_done();

    // R6: bad stop, sticky through a good frame, then clear
    send(9'h077, 1'b0); cmp_all("R6");
    clr_done();
    send(9'h011, 1'b1); cmp_all("R6");
    clr_ferr(); cmp_all("R6");
    clr_done();

    // R8/R9: filtering, long frames, exact address
    nine = 1'b1; mp_en = 1'b1; addr = 8'h42; mask = 8'h00;
    send(9'h142, 1'b1); cmp_all("R9");
    clr_done();
    send(9'h143, 1'b1); cmp_all("R8");
    send(9'h042, 1'b1); cmp_all("R8");

    // R9 with mask, R10 broadcast
    mask = 8'h03;
    send(9'h141, 1'b1); cmp_all("R9");
    clr_done();
    send(9'h1C3, 1'b1); cmp_all("R10");
    clr_done();
    send(9'h183, 1'b1); cmp_all("R10");
    send(9'h1FF, 1'b1); cmp_all("R10");
    clr_done();

    // R8: short frames, stop bit as qualifier
    nine = 1'b0; mask = 8'h00;
    send(9'h042, 1'b1); cmp_all("R8");
    clr_done();
    send(9'h042, 1'b0); cmp_all("R8");
    clr_ferr();

    // R7: set wins against a held clear
    mp_en = 1'b0;
    done_clr = 1'b1; repeat (2) @(negedge clk);
    done_hi = 0; mon_on = 1'b1;
    send(9'h099, 1'b1);
    mon_on = 1'b0; done_clr = 1'b0; e_done = 1'b0;
    chk("R7", "done cycles under held clear", done_hi, 1);
    cmp_all("R7");

    // R6: framing error wins against a held clear
    ferr_clr = 1'b1; repeat (2) @(negedge clk);
    ferr_hi = 0; mon_on = 1'b1;
    send(9'h066, 1'b0);
    mon_on = 1'b0; ferr_clr = 1'b0; e_ferr = 1'b0;
    chk("R6", "ferr cycles under held clear", ferr_hi, 1);
    cmp_all("R6");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule